// File: doc/BRIEF.md
# Master Interrupt Mask Controller

The controller gathers interrupt requests from up to 32 device lines and presents one request line per source towards the processor. Each device line is a level signal that is sampled synchronously. A rising level latches a pending flag for that source. A per-source disable flag decides whether a latched request is passed on. A fixed parameter, `IMPL_MASK`, marks which bit positions exist. Bit positions outside that mask never hold state and never raise a request.

Software drives the mask through two write-only words. One word re-enables the sources whose data bits are 1, and the other disables them. Disabling a source discards its latched request at that moment. A request that arrives while the source is disabled is still latched and reaches the processor as soon as the source is enabled again, so a disable-then-enable sequence clears what was pending before the disable. Two read words expose the pending and disable registers.

Each source is a small four-state machine:
- `SRC_OFF_IDLE`: disabled, nothing latched.
- `SRC_OFF_HELD`: disabled, a request latched.
- `SRC_ON_IDLE`: enabled, nothing latched.
- `SRC_ON_LIVE`: enabled, a request latched; the processor line is raised.

The named transitions are:
- disable: any state goes to `SRC_OFF_IDLE`.
- enable: `SRC_OFF_IDLE` goes to `SRC_ON_IDLE`, or to `SRC_ON_LIVE` if a rise coincides; `SRC_OFF_HELD` goes to `SRC_ON_LIVE`.
- rise: `SRC_OFF_IDLE` goes to `SRC_OFF_HELD`; `SRC_ON_IDLE` goes to `SRC_ON_LIVE`.
- all other combinations hold the current state.

Top module: `master_irq_mask`

## Requirements
- R1: After reset every implemented source is disabled (disable register reads `IMPL_MASK`), the pending register reads 0 and `cpu_req` is 0.
- R2: The register word is the byte address shifted right by two. A write to word 2 (byte addresses 8 to 11) clears the disable bit of every source whose data bit is 1; the new state shows on the cycle after the write edge.
- R3: A write to word 3 (byte addresses 12 to 15) sets the disable bit of every source whose data bit is 1.
- R4: Write data is ANDed with `IMPL_MASK` before any enable or disable. Unimplemented bits (bit 31 by default) always read 0 in both registers, and their device lines never raise `cpu_req`.
- R5: A 0-to-1 change on `dev_req[i]`, seen at a clock edge, sets pending bit i at that edge. A line that stays high does not set it again.
- R6: A disable write clears the pending bit of each source it names, at the same edge. This includes a source that is already disabled, and it wins over a rise in the same cycle.
- R7: A rise on a disabled source is latched, and `cpu_req` for that source goes high at the edge of the enable write.
- R8: `cpu_req[i]` equals pending bit i AND NOT disable bit i, and it follows every enable or disable write with no extra delay.
- R9: A read of word 0 returns the pending register, word 1 returns the disable register, and every other word reads 0.
- R10: Writes to words 0 and 1 change no state.
- R11: Enabling a source that is already enabled does not clear its pending bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | DATA_W | Write data, one bit per source |
| bus_rdata | output | DATA_W | Read data selected by `bus_addr` (combinational) |
| dev_req | input | DATA_W | Level request lines from the devices |
| cpu_req | output | DATA_W | Request lines towards the processor |

## Verification
A source machine stuck in the wrong state appears within one cycle of the next write or rise. `cpu_req` disagrees at once, and the pending and disable reads disagree on the very next bus read. The bench walks sequences that move each source through every named transition: a disable during a held request, a redundant disable, a redundant enable, and a rise while disabled. It reads both registers after every step. If decode confuses the two write words or forgets the implemented mask, the disable read is wrong on the cycle after the write.

// File: rtl/mic_pkg.sv
package mic_pkg;
    typedef enum logic [1:0] {
        SRC_OFF_IDLE = 2'd0,
        SRC_OFF_HELD = 2'd1,
        SRC_ON_IDLE  = 2'd2,
        SRC_ON_LIVE  = 2'd3
    } src_state_t;

    localparam int unsigned WORD_PEND    = 0;
    localparam int unsigned WORD_DIS     = 1;
    localparam int unsigned WORD_ENABLE  = 2;
    localparam int unsigned WORD_DISABLE = 3;
endpackage

// File: rtl/mic_decode.sv
module mic_decode
    import mic_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32,
    parameter logic [DATA_W-1:0] IMPL_MASK = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] pend_vec,
    input  logic [DATA_W-1:0] dis_vec,
    output logic [DATA_W-1:0] en_stb,
    output logic [DATA_W-1:0] dis_stb,
    output logic [DATA_W-1:0] bus_rdata
);
    logic [ADDR_W-1:0] word_idx;
    logic [DATA_W-1:0] masked_data;

    assign word_idx    = bus_addr >> 2;
    assign masked_data = bus_wdata & IMPL_MASK;

    always_comb begin
        en_stb  = '0;
        dis_stb = '0;
        if (bus_we) begin
            if (word_idx == ADDR_W'(WORD_ENABLE))  en_stb  = masked_data;
            if (word_idx == ADDR_W'(WORD_DISABLE)) dis_stb = masked_data;
        end
    end

    always_comb begin
        if (word_idx == ADDR_W'(WORD_PEND))     bus_rdata = pend_vec;
        else if (word_idx == ADDR_W'(WORD_DIS)) bus_rdata = dis_vec;
        else                                    bus_rdata = '0;
    end

    assert_read_other_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (word_idx > ADDR_W'(WORD_DIS)) |-> (bus_rdata == '0));
    assert_strobe_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((en_stb & dis_stb) == '0));
endmodule

// File: rtl/mic_src_cell.sv
module mic_src_cell
    import mic_pkg::*;
#(
    parameter bit PRESENT = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dev_level,
    input  logic en_stb,
    input  logic dis_stb,
    output logic pending,
    output logic disabled,
    output logic irq
);
    src_state_t state_q, state_d;
    logic       prev_level;
    logic       rise;

    assign rise = PRESENT && dev_level && !prev_level;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= SRC_OFF_IDLE;
            prev_level <= 1'b0;
        end else begin
            state_q    <= state_d;
            prev_level <= dev_level;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SRC_OFF_IDLE: begin
                if (dis_stb)     state_d = SRC_OFF_IDLE;
                else if (en_stb) state_d = rise ? SRC_ON_LIVE : SRC_ON_IDLE;
                else if (rise)   state_d = SRC_OFF_HELD;
            end
            SRC_OFF_HELD: begin
                if (dis_stb)     state_d = SRC_OFF_IDLE;
                else if (en_stb) state_d = SRC_ON_LIVE;
            end
            SRC_ON_IDLE: begin
                if (dis_stb)     state_d = SRC_OFF_IDLE;
                else if (rise)   state_d = SRC_ON_LIVE;
            end
            SRC_ON_LIVE: begin
                if (dis_stb)     state_d = SRC_OFF_IDLE;
            end
            default: state_d = SRC_OFF_IDLE;
        endcase
    end

    always_comb begin
        pending  = (state_q == SRC_OFF_HELD) || (state_q == SRC_ON_LIVE);
        disabled = (state_q == SRC_OFF_IDLE) || (state_q == SRC_OFF_HELD);
        irq      = (state_q == SRC_ON_LIVE);
    end

    assert_rise_latches_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && !dis_stb) |=> pending);
    assert_disable_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dis_stb |=> (!pending && disabled));
    assert_enable_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_stb && pending && disabled) |=> irq);
    assert_enable_keeps_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (en_stb && pending && !disabled) |=> pending);
endmodule

// File: rtl/master_irq_mask.sv
module master_irq_mask
    import mic_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32,
    parameter logic [DATA_W-1:0] IMPL_MASK = 32'h7FFF_FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] dev_req,
    output logic [DATA_W-1:0] cpu_req
);
    logic [DATA_W-1:0] en_stb, dis_stb, pend_vec, dis_vec;

    mic_decode #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .IMPL_MASK(IMPL_MASK)
    ) decode_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .pend_vec (pend_vec),
        .dis_vec  (dis_vec),
        .en_stb   (en_stb),
        .dis_stb  (dis_stb),
        .bus_rdata(bus_rdata)
    );

    logic [DATA_W-1:0] cell_dis;

    for (genvar i = 0; i < DATA_W; i++) begin : g_src
        mic_src_cell #(.PRESENT(IMPL_MASK[i])) cell_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .dev_level(dev_req[i]),
            .en_stb   (en_stb[i]),
            .dis_stb  (dis_stb[i]),
            .pending  (pend_vec[i]),
            .disabled (cell_dis[i]),
            .irq      (cpu_req[i])
        );
    end

    assign dis_vec = cell_dis & IMPL_MASK;

    assert_unimpl_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_vec & ~IMPL_MASK) == '0));
endmodule

// File: tb/master_irq_mask_tb.sv
module master_irq_mask_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] IMPL = 32'h7FFF_FFFF;

    typedef struct packed {
        logic        we;
        logic [3:0]  addr;
        logic [31:0] wdata;
        logic [31:0] req;
        logic [31:0] exp_cpu;
        logic [31:0] exp_pend;
        logic [31:0] exp_dis;
    } vec_t;

    localparam int NVEC = 18;
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 4'h8, 32'hFFFF_FFFF, 32'h0, 32'h0, 32'h0, 32'h0},          // R2 R4 enable all, bit31 masked
        '{1'b0, 4'h0, 32'h0, 32'h5, 32'h5, 32'h5, 32'h0},                 // R5 rise
        '{1'b0, 4'h0, 32'h0, 32'h5, 32'h5, 32'h5, 32'h0},                 // R5 level held
        '{1'b0, 4'h0, 32'h0, 32'h0, 32'h5, 32'h5, 32'h0},                 // R5 fall keeps pending
        '{1'b1, 4'hC, 32'h1, 32'h0, 32'h4, 32'h4, 32'h1},                 // R3 R6 R8 disable bit0
        '{1'b0, 4'h0, 32'h0, 32'h1, 32'h4, 32'h5, 32'h1},                 // R7 held while disabled
        '{1'b1, 4'h8, 32'h1, 32'h1, 32'h5, 32'h5, 32'h0},                 // R7 R8 enable releases
        '{1'b1, 4'h8, 32'h4, 32'h1, 32'h5, 32'h5, 32'h0},                 // R11 redundant enable
        '{1'b1, 4'h0, 32'hFFFF_FFFF, 32'h0, 32'h5, 32'h5, 32'h0},         // R10 write word0
        '{1'b1, 4'h4, 32'hFFFF_FFFF, 32'h0, 32'h5, 32'h5, 32'h0},         // R10 write word1
        '{1'b1, 4'hE, 32'h8000_0000, 32'h0, 32'h5, 32'h5, 32'h0},         // R4 R2 disable masked bit
        '{1'b1, 4'hD, 32'h6, 32'h0, 32'h1, 32'h1, 32'h6},                 // R6 disable clears bit2
        '{1'b0, 4'h0, 32'h0, 32'h8000_0000, 32'h1, 32'h1, 32'h6},         // R4 unimplemented line
        '{1'b0, 4'h0, 32'h0, 32'h2, 32'h1, 32'h3, 32'h6},                 // R7 held bit1
        '{1'b1, 4'hC, 32'h2, 32'h2, 32'h1, 32'h1, 32'h6},                 // R6 redundant disable clears held
        '{1'b1, 4'h9, 32'h6, 32'h2, 32'h1, 32'h1, 32'h0},                 // R2 enable, line still high
        '{1'b0, 4'h0, 32'h0, 32'h0, 32'h1, 32'h1, 32'h0},                 // R5 line low
        '{1'b0, 4'h0, 32'h0, 32'h2, 32'h3, 32'h3, 32'h0}                  // R5 R8 new rise
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] dev_req = '0;
    logic [31:0] cpu_req;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    master_irq_mask dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .dev_req  (dev_req),
        .cpu_req  (cpu_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic read_word(input logic [3:0] a, output logic [31:0] d);
        bus_we   = 1'b0;
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic check_state(input string req, input logic [31:0] ecpu,
                               input logic [31:0] epend, input logic [31:0] edis);
        logic [31:0] d;
        check({req, " cpu_req"}, cpu_req, ecpu);
        read_word(4'h0, d);
        check({req, " pending"}, d, epend);
        read_word(4'h4, d);
        check({req, " disable"}, d, edis);
    endtask

    task automatic step(input logic we, input logic [3:0] a, input logic [31:0] wd,
                        input logic [31:0] rq);
        bus_we    = we;
        bus_addr  = a;
        bus_wdata = wd;
        dev_req   = rq;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check_state("R1", 32'h0, 32'h0, IMPL);

        for (int k = 0; k < NVEC; k++) begin
            step(VEC[k].we, VEC[k].addr, VEC[k].wdata, VEC[k].req);
            check_state($sformatf("vector %0d", k), VEC[k].exp_cpu,
                        VEC[k].exp_pend, VEC[k].exp_dis);
        end

        // R9: other words read zero while registers are non-zero
        read_word(4'h8, d);  check("R9 word2 read", d, 32'h0);
        read_word(4'hC, d);  check("R9 word3 read", d, 32'h0);
        read_word(4'hF, d);  check("R9 word3 high byte", d, 32'h0);
        read_word(4'h3, d);  check("R9 word0 alias", d, 32'h3);

        // R6: disable wins over a rise in the same cycle
        step(1'b0, 4'h0, 32'h0, 32'h0);
        step(1'b1, 4'hC, 32'h8, 32'h8);
        check_state("R6 disable with rise", 32'h3, 32'h3, 32'h8);
        step(1'b1, 4'h8, 32'h8, 32'h8);
        check_state("R6 enable after lost rise", 32'h3, 32'h3, 32'h0);

        // R7: enable in the same cycle as a rise
        step(1'b1, 4'hC, 32'h10, 32'h0);
        step(1'b1, 4'h8, 32'h10, 32'h10);
        check_state("R7 enable with rise", 32'h13, 32'h13, 32'h0);

        // R1: reset during operation
        rst_n = 1'b0;
        dev_req = '0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check_state("R1 mid-run reset", 32'h0, 32'h0, IMPL);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule